// File: doc/BRIEF.md
# Bitfield Manipulation Unit

This block is the scalar bit-manipulation datapath of one shader lane. It takes a 32-bit operand plus an insert operand, an offset and a width, and forms one of eight results chosen by an operation code. The results are zero- or sign-extended field extraction, field insertion into a base word, full bit reversal, population count, and three searches for a set bit: lowest set, highest set, and highest bit that differs from the sign.

Offset and width are reduced to their low five bits before use, so every request stays inside the word. The result path is combinational. A parameter can place one register stage on the output, which gives a single-cycle pipeline step.

Top module: `bfu_top`

## Requirements
- R1: Extract and insert use only bits [4:0] of `offset_i` and of `bits_i`. All higher bits of those two inputs have no effect on the result.
- R2: Extract, signed or unsigned, returns 0 when the masked width is 0, whatever the value and offset.
- R3: Unsigned extract (op 0) returns the field of `value_i` that starts at the offset and has the given width, zero-extended. When offset plus width is 32 or more, it returns `value_i` logically shifted right by the offset.
- R4: Signed extract (op 1) returns the same field with its top bit (bit width-1) copied into all higher bits. When offset plus width is 32 or more, it returns `value_i` arithmetically shifted right by the offset.
- R5: Insert (op 2) replaces the bits of `value_i` in positions offset to offset+width-1 that lie below 32 with the low bits of `insert_i`. All other bits keep their base value. A masked width of 0 returns `value_i` unchanged.
- R6: Reverse (op 3) puts input bit i at output bit 31-i.
- R7: Count (op 4) returns the number of 1 bits in `value_i`.
- R8: Find-lowest (op 5) returns the index of the least significant 1, or 0xFFFFFFFF for a zero input.
- R9: Find-highest (op 6) returns the index of the most significant 1, or 0xFFFFFFFF for a zero input.
- R10: Signed find-highest (op 7) returns the index of the highest bit that differs from bit 31. It returns 0xFFFFFFFF for the inputs 0x00000000 and 0xFFFFFFFF.
- R11: Op codes 8 to 15 give a result of 0.
- R12: With `OUT_REG`=1 (the default), the result appears on `result_o` one clock after its inputs and is 0 during reset. With `OUT_REG`=0 the path is purely combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation select (codes in R3 to R11) |
| value_i | input | 32 | Source operand; base word for insert |
| insert_i | input | 32 | Field source for insert |
| offset_i | input | 32 | Field start bit; only [4:0] used |
| bits_i | input | 32 | Field width; only [4:0] used |
| result_o | output | 32 | Operation result |

## Verification
On every cycle, the assertions check properties of each datapath unit. An unsigned extract has no bits set above its width. A signed extract is sign-uniform above bit width-1. Insert leaves the bits below the offset untouched. The find results point at a set bit, and no lower set bit exists below a find-lowest result. Count never exceeds 32, and the sign-aware search returns -1 for uniform inputs. Only the bench's sweeps can show exact field values, the switch to a plain shift at the offset-plus-width boundary, masking of the upper offset and width bits, and the output register's latency and reset value. The sweeps cover all 1024 offset and width pairs for every extract and insert op, plus random operands on all codes.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [3:0] {
    BF_UEXT  = 4'd0,
    BF_SEXT  = 4'd1,
    BF_INS   = 4'd2,
    BF_REV   = 4'd3,
    BF_CNT   = 4'd4,
    BF_LOW   = 4'd5,
    BF_HIGH  = 4'd6,
    BF_SHIGH = 4'd7
  } bf_op_e;
endpackage

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [SH_W-1:0]   off_i,
  input  logic [SH_W-1:0]   wid_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] res_o
);
  localparam logic [SH_W:0] FULL = (SH_W+1)'(DATA_W);

  logic [SH_W:0]       span;
  logic [SH_W:0]       lsh_amt;
  logic [SH_W:0]       rsh_amt;
  logic [DATA_W-1:0]   lsh;

  always_comb begin
    span    = {1'b0, off_i} + {1'b0, wid_i};
    lsh_amt = FULL - span;
    rsh_amt = FULL - {1'b0, wid_i};
    lsh     = value_i << lsh_amt;
    if (wid_i == '0) begin
      res_o = '0;
    end else if (span < FULL) begin
      // field lands at MSB, then shifts back down with or without sign fill
      res_o = sext_i ? DATA_W'($signed(lsh) >>> rsh_amt) : (lsh >> rsh_amt);
    end else begin
      res_o = sext_i ? DATA_W'($signed(value_i) >>> off_i) : (value_i >> off_i);
    end
  end
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] ins_i,
  input  logic [SH_W-1:0]   off_i,
  input  logic [SH_W-1:0]   wid_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask  = ((DATA_W'(1) << wid_i) - DATA_W'(1)) << off_i;
    res_o = ((ins_i << off_i) & mask) | (base_i & ~mask);
  end
endmodule

// File: rtl/bfu_scan.sv
module bfu_scan #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] value_i,
  output logic [DATA_W-1:0] rev_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] low_o,
  output logic [DATA_W-1:0] high_o,
  output logic [DATA_W-1:0] shigh_o
);
  function automatic logic [DATA_W-1:0] top_one(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (v[i]) r = DATA_W'(i);
    end
    return r;
  endfunction

  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign rev_o[g] = value_i[DATA_W-1-g];
  end

  logic [DATA_W-1:0] folded;

  always_comb begin
    cnt_o = '0;
    low_o = '1;
    for (int i = DATA_W-1; i >= 0; i--) begin
      cnt_o = cnt_o + CNT_W'(value_i[i]);
      if (value_i[i]) low_o = DATA_W'(i);
    end
    high_o  = top_one(value_i);
    // fold by sign: the top differing bit becomes the top one
    folded  = value_i ^ {DATA_W{value_i[DATA_W-1]}};
    shigh_o = top_one(folded);
  end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] insert_i,
  input  logic [DATA_W-1:0] offset_i,
  input  logic [DATA_W-1:0] bits_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int SH_W  = $clog2(DATA_W);
  localparam int CNT_W = SH_W + 1;

  logic [SH_W-1:0]   off_m, wid_m;
  logic              unused_hi;
  logic [DATA_W-1:0] uext_res, sext_res, ins_res;
  logic [DATA_W-1:0] rev_res, low_res, high_res, shigh_res;
  logic [CNT_W-1:0]  cnt_res;
  logic [DATA_W-1:0] res_d;

  assign off_m     = offset_i[SH_W-1:0];
  assign wid_m     = bits_i[SH_W-1:0];
  assign unused_hi = ^{offset_i[DATA_W-1:SH_W], bits_i[DATA_W-1:SH_W]};

  bfu_extract #(.DATA_W(DATA_W), .SH_W(SH_W)) u_uext (
    .value_i(value_i), .off_i(off_m), .wid_i(wid_m), .sext_i(1'b0), .res_o(uext_res)
  );

  bfu_extract #(.DATA_W(DATA_W), .SH_W(SH_W)) u_sext (
    .value_i(value_i), .off_i(off_m), .wid_i(wid_m), .sext_i(1'b1), .res_o(sext_res)
  );

  bfu_insert #(.DATA_W(DATA_W), .SH_W(SH_W)) u_ins (
    .base_i(value_i), .ins_i(insert_i), .off_i(off_m), .wid_i(wid_m), .res_o(ins_res)
  );

  bfu_scan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_scan (
    .value_i(value_i), .rev_o(rev_res), .cnt_o(cnt_res),
    .low_o(low_res), .high_o(high_res), .shigh_o(shigh_res)
  );

  always_comb begin
    case (op_i)
      BF_UEXT:  res_d = uext_res;
      BF_SEXT:  res_d = sext_res;
      BF_INS:   res_d = ins_res;
      BF_REV:   res_d = rev_res;
      BF_CNT:   res_d = DATA_W'(cnt_res);
      BF_LOW:   res_d = low_res;
      BF_HIGH:  res_d = high_res;
      BF_SHIGH: res_d = shigh_res;
      default:  res_d = '0;
    endcase
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) result_o <= '0;
      else         result_o <= res_d;
    end
  end else begin : g_comb
    assign result_o = res_d;
  end

  // R3
  uext_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_m != '0) |-> ((uext_res >> wid_m) == '0));

  // R4
  sext_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_m != '0) |-> ((($signed(sext_res) >>> (wid_m - 1'b1)) == 0) ||
                       (($signed(sext_res) >>> (wid_m - 1'b1)) == -1)));

  // R5
  ins_low_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (((ins_res ^ value_i) & ((DATA_W'(1) << off_m) - DATA_W'(1))) == '0));

  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (cnt_res <= CNT_W'(DATA_W)));

  // R8
  low_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_res != '1) |-> (value_i[low_res[SH_W-1:0]] &&
      ((value_i & ((DATA_W'(1) << low_res[SH_W-1:0]) - DATA_W'(1))) == '0)));

  // R9
  high_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (high_res != '1) |-> value_i[high_res[SH_W-1:0]]);

  // R10
  shigh_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((value_i == '0) || (value_i == '1)) |-> (shigh_res == '1));
endmodule

// File: tb/bfu_top_bench.sv
module bfu_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] value_i = '0, insert_i = '0, offset_i = '0, bits_i = '0;
  logic [31:0] result_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bfu_top u_bfu_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .value_i(value_i),
    .insert_i(insert_i), .offset_i(offset_i), .bits_i(bits_i), .result_o(result_o)
  );

  function automatic logic [31:0] model(logic [3:0] op, logic [31:0] v, logic [31:0] ins,
                                        logic [31:0] offr, logic [31:0] bitsr);
    int o, w, top;
    logic [31:0] r;
    o = int'(offr & 32'h1f);
    w = int'(bitsr & 32'h1f);
    r = '0;
    case (op)
      4'd0, 4'd1: begin
        if (w != 0) begin
          top = (o + w < 32) ? w - 1 : 31 - o;
          for (int i = 0; i < 32; i++) begin
            if (i <= top) r[i] = v[o+i];
            else          r[i] = (op == 4'd1) ? v[o+top] : 1'b0;
          end
        end
      end
      4'd2: for (int i = 0; i < 32; i++)
              r[i] = (i >= o && i < o + w) ? ins[i-o] : v[i];
      4'd3: for (int i = 0; i < 32; i++) r[i] = v[31-i];
      4'd4: for (int i = 0; i < 32; i++) r = r + 32'(v[i]);
      4'd5: begin
        r = '1;
        for (int i = 0; i < 32; i++) if (v[i] && r == '1) r = 32'(i);
      end
      4'd6: begin
        r = '1;
        for (int i = 31; i >= 0; i--) if (v[i] && r == '1) r = 32'(i);
      end
      4'd7: begin
        r = '1;
        for (int i = 30; i >= 0; i--) if (v[i] != v[31] && r == '1) r = 32'(i);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R9";
      4'd7: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    n_run++;
    if (result_o !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d v=%h ins=%h off=%h bits=%h got=%h exp=%h",
               tag, op_i, value_i, insert_i, offset_i, bits_i, result_o, exp);
    end
  endtask

  // drive at negedge, registered output sampled just after the next posedge (R12)
  task automatic run(logic [3:0] op, logic [31:0] v, logic [31:0] ins,
                     logic [31:0] o, logic [31:0] b, string tag);
    @(negedge clk_i);
    op_i = op; value_i = v; insert_i = ins; offset_i = o; bits_i = b;
    @(posedge clk_i);
    #1;
    check(tag, model(op, v, ins, o, b));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [4];
    vals[0] = 32'hA5C3_96F1;
    vals[1] = 32'h7FFF_0001;
    vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h8000_0000;

    op_i = 4'd3; value_i = 32'h1234_5678;
    repeat (3) @(posedge clk_i);
    #1;
    check("R12 reset", 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R12 one-cycle latency: output still holds old value before the edge
    @(negedge clk_i); op_i = 4'd4; value_i = 32'h0000_00FF;
    @(posedge clk_i); #1; check("R12 latency", 32'd8);
    @(negedge clk_i); value_i = 32'h0000_000F; #1; check("R12 hold", 32'd8);
    @(posedge clk_i); #1; check("R12 update", 32'd4);

    // near-exhaustive offset x width sweep for extract and insert
    for (int op = 0; op < 3; op++)
      for (int vi = 0; vi < 4; vi++)
        for (int o = 0; o < 32; o++)
          for (int w = 0; w < 32; w++)
            run(4'(op), vals[vi], ~vals[(vi+1)%4], 32'(o), 32'(w), tag_of(4'(op)));

    // R2 zero width
    run(4'd0, 32'hFFFF_FFFF, 0, 32'd3, 32'd0, "R2");
    run(4'd1, 32'hFFFF_FFFF, 0, 32'd0, 32'd32, "R2");
    // R5 zero width insert keeps base
    run(4'd2, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'd7, 32'd0, "R5");
    // R1 upper bits of offset/width ignored
    run(4'd0, 32'hF0F0_1234, 0, 32'hFFFF_FFE4, 32'h1234_5608, "R1");
    run(4'd1, 32'h0080_0000, 0, 32'h8000_0010, 32'hC000_0008, "R1");
    run(4'd2, 32'h0000_0000, 32'hFFFF_FFFF, 32'hABCD_EF1C, 32'h0000_0124, "R1");
    // boundary: offset+width exactly 32 -> plain shift
    run(4'd1, 32'h8000_0000, 0, 32'd16, 32'd16, "R4");
    run(4'd0, 32'h8000_0000, 0, 32'd31, 32'd1, "R3");
    // scans
    run(4'd5, 32'h0, 0, 0, 0, "R8");
    run(4'd5, 32'h8000_0000, 0, 0, 0, "R8");
    run(4'd6, 32'h0, 0, 0, 0, "R9");
    run(4'd6, 32'h0000_0001, 0, 0, 0, "R9");
    run(4'd7, 32'h0, 0, 0, 0, "R10");
    run(4'd7, 32'hFFFF_FFFF, 0, 0, 0, "R10");
    run(4'd7, 32'hFFFF_FFFE, 0, 0, 0, "R10");
    run(4'd7, 32'h4000_0000, 0, 0, 0, "R10");
    run(4'd4, 32'hFFFF_FFFF, 0, 0, 0, "R7");
    run(4'd3, 32'h0000_0001, 0, 0, 0, "R6");
    for (int op = 8; op < 16; op++) run(4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 4, "R11");

    // random operands on all op codes
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] rop;
      rop = 4'($urandom_range(0, 15));
      run(rop, $urandom, $urandom, $urandom, $urandom, tag_of(rop));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule